// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block sits between a 10 Mb/s twisted-pair transmit path and its line driver and guards the network against a transmitter that never turns off. It counts how long the serial transmit-enable `tx_active` has been held continuously. If that run reaches a configured maximum, the block enters a jammed state. In that state it gates the transmitter off, raises the collision indication toward the MAC, and latches a sticky status flag.

The jammed state is left only after `tx_active` has been absent for a separate, longer quiet interval without a break. Any return of transmit activity during that interval restarts it. The status flag survives recovery until software pulses the clear strobe or reset is applied. The block also passes through a collision input from the line side and stretches its trailing edge by a fixed number of cycles, corresponding to two bit times. Both timing windows and the stretch length are parameters in clock cycles. A real part sets them for windows of tens to hundreds of milliseconds, and simulation uses short values.

Top module: `jabber_guard`

## Requirements
- R1: After reset is released, with all inputs low, `tx_gate`, `col_out` and `jab_status` are all 0 and the block is in the running (not jammed) state.
- R2: While not jammed, `tx_gate` equals `tx_active` in the same cycle.
- R3: When `tx_active` is sampled high on JAB_CYCLES consecutive rising clock edges, the block is jammed from that edge on, and `tx_gate` is 0 for as long as it stays jammed, whatever `tx_active` does.
- R4: The run count restarts from zero whenever `tx_active` is sampled low before the limit is reached, so bursts of JAB_CYCLES-1 separated by one idle cycle never trip.
- R5: While jammed, `col_out` is 1.
- R6: `jab_status` becomes 1 on the edge that trips the block, and stays 1 afterwards (including after recovery) until cleared.
- R7: A jammed block returns to running on the edge where `tx_active` has been sampled low on UNJAB_CYCLES consecutive edges; a high sample during the quiet interval restarts it from zero.
- R8: A `clr_status` pulse sampled at an edge clears `jab_status`, except on the edge that trips the block, where setting wins.
- R9: `col_out` is 1 while `col_in` is 1 and stays 1 for COL_HOLD further cycles after the last edge on which `col_in` was sampled high.
- R10: After recovery the run count starts fresh, so a run of JAB_CYCLES-1 active cycles right after release does not trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 1 | Serial transmit-enable from the MAC side |
| col_in | input | 1 | Collision detected on the line |
| clr_status | input | 1 | Strobe that clears the sticky jabber flag |
| tx_gate | output | 1 | Transmit enable toward the line driver |
| col_out | output | 1 | Collision indication toward the MAC |
| jab_status | output | 1 | Sticky jabber flag |

## Verification
The hardest case to reach is recovery that begins and is then interrupted. The stimulus has to hold `tx_active` past the trip point. It then drops it for part of the quiet interval, raises it for two cycles, and drops it again. The release should then land exactly UNJAB_CYCLES edges after the second drop. The bench builds this sequence with short parameter values. It also drives a clear strobe on the very edge of a second trip, so that the set-over-clear priority is seen at the ports.

// File: rtl/jg_pkg.sv
package jg_pkg;
  typedef enum logic {
    JG_RUN    = 1'b0,
    JG_JAMMED = 1'b1
  } jg_state_e;
endpackage

// File: rtl/jg_run_counter.sv
// Counts consecutive enabled cycles; hit pulses on the LIMIT-th one and the
// count wraps to zero. clear has priority over en.
module jg_run_counter #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clear,
  output logic hit
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign hit = en && !clear && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)    cnt_d = '0;
    else if (en)  cnt_d = hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/jg_col_stretch.sv
// Extends the trailing edge of a collision indication by HOLD cycles.
module jg_col_stretch #(
  parameter int unsigned HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic col_in,
  output logic col_ext
);
  generate
    if (HOLD == 0) begin : g_pass
      assign col_ext = col_in;
    end else begin : g_hold
      localparam int unsigned W = $clog2(HOLD + 1);
      logic [W-1:0] hold_q, hold_d;

      always_comb begin
        hold_d = hold_q;
        if (col_in)            hold_d = W'(HOLD);
        else if (hold_q != '0) hold_d = hold_q - 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
      end

      assign col_ext = col_in || (hold_q != '0);
    end
  endgenerate
endmodule

// File: rtl/jabber_guard.sv
module jabber_guard #(
  parameter int unsigned JAB_CYCLES   = 2_000_000,
  parameter int unsigned UNJAB_CYCLES = 50_000_000,
  parameter int unsigned COL_HOLD     = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic col_in,
  input  logic clr_status,
  output logic tx_gate,
  output logic col_out,
  output logic jab_status
);
  import jg_pkg::*;

  jg_state_e state_q, state_d;
  logic      jammed;
  logic      win_hit, quiet_hit, trip;
  logic      status_q, status_d;
  logic      col_ext;

  assign jammed = (state_q == JG_JAMMED);

  // Continuous-activity window while running
  jg_run_counter #(.LIMIT(JAB_CYCLES)) u_win (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (tx_active),
    .clear(!tx_active || jammed),
    .hit  (win_hit)
  );

  // Quiet interval while jammed
  jg_run_counter #(.LIMIT(UNJAB_CYCLES)) u_quiet (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (!tx_active),
    .clear(tx_active || !jammed),
    .hit  (quiet_hit)
  );

  jg_col_stretch #(.HOLD(COL_HOLD)) u_col (
    .clk    (clk),
    .rst_n  (rst_n),
    .col_in (col_in),
    .col_ext(col_ext)
  );

  assign trip = !jammed && win_hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      JG_RUN:    if (win_hit)   state_d = JG_JAMMED;
      JG_JAMMED: if (quiet_hit) state_d = JG_RUN;
      default:                  state_d = JG_RUN;
    endcase
  end

  always_comb begin
    status_d = status_q;
    if (trip)            status_d = 1'b1;
    else if (clr_status) status_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= JG_RUN;
      status_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
    end
  end

  assign tx_gate    = tx_active && !jammed;
  assign col_out    = jammed || col_ext;
  assign jab_status = status_q;
endmodule

// File: rtl/jabber_guard_chk.sv
module jabber_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_active,
  input logic col_in,
  input logic clr_status,
  input logic tx_gate,
  input logic col_out,
  input logic jab_status,
  input logic jammed
);
  a_r2_gate_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !jammed |-> (tx_gate == tx_active));

  a_r3_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    jammed |-> !tx_gate);

  a_r5_col_jammed: assert property (@(posedge clk) disable iff (!rst_n)
    jammed |-> col_out);

  a_r6_status_on_trip: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jammed) |-> jab_status);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (jab_status && !clr_status) |=> jab_status);

  a_r7_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jammed) |-> $past(!tx_active));

  a_r9_col_pass: assert property (@(posedge clk) disable iff (!rst_n)
    col_in |-> col_out);
endmodule

bind jabber_guard jabber_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_active (tx_active),
  .col_in    (col_in),
  .clr_status(clr_status),
  .tx_gate   (tx_gate),
  .col_out   (col_out),
  .jab_status(jab_status),
  .jammed    (jammed)
);

// File: tb/jabber_guard_bench.sv
`timescale 1ns/1ps
module jabber_guard_bench;
  localparam int JAB   = 16;
  localparam int UNJAB = 40;
  localparam int HOLD  = 3;

  logic clk, rst_n, tx_active, col_in, clr_status;
  logic tx_gate, col_out, jab_status;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference model state
  int  m_run, m_quiet, m_hold;
  bit  m_jam, m_stat;

  jabber_guard #(.JAB_CYCLES(JAB), .UNJAB_CYCLES(UNJAB), .COL_HOLD(HOLD)) u_jabber_guard (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .col_in(col_in),
    .clr_status(clr_status), .tx_gate(tx_gate), .col_out(col_out),
    .jab_status(jab_status)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_quiet = 0; m_hold = 0; m_jam = 0; m_stat = 0;
    end else begin
      bit trip;
      trip = 0;
      if (!m_jam) begin
        if (tx_active) begin
          m_run++;
          if (m_run == JAB) begin trip = 1; m_jam = 1; m_run = 0; end
        end else m_run = 0;
      end else begin
        if (!tx_active) begin
          m_quiet++;
          if (m_quiet == UNJAB) begin m_jam = 0; m_quiet = 0; end
        end else m_quiet = 0;
      end
      if (trip) m_stat = 1;
      else if (clr_status) m_stat = 0;
      if (col_in) m_hold = HOLD;
      else if (m_hold > 0) m_hold--;
    end
  end

  task automatic check1(input logic act, input logic exp, input string what, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic tx, input logic col, input logic clr, input string tag);
    @(negedge clk);
    tx_active = tx; col_in = col; clr_status = clr;
    #1;
    check1(tx_gate, tx && !m_jam, "tx_gate", tag);
    check1(col_out, m_jam || col || (m_hold > 0), "col_out", tag);
    check1(jab_status, m_stat, "jab_status", tag);
  endtask

  task automatic run(input int n, input logic tx, input logic col, input logic clr, input string tag);
    for (int i = 0; i < n; i++) step(tx, col, clr, tag);
  endtask

  task automatic finish_up();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    rst_n = 0; tx_active = 0; col_in = 0; clr_status = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle outputs after reset
    run(4, 0, 0, 0, "R1");
    // R2: ordinary bursts pass through
    run(5, 1, 0, 0, "R2"); run(3, 0, 0, 0, "R2");
    run(1, 1, 0, 0, "R2"); run(2, 0, 0, 0, "R2");
    // R4: near-limit bursts separated by single idle cycles
    run(JAB-1, 1, 0, 0, "R4"); run(1, 0, 0, 0, "R4");
    run(JAB-1, 1, 0, 0, "R4"); run(1, 0, 0, 0, "R4");
    run(JAB-1, 1, 0, 0, "R4"); run(3, 0, 0, 0, "R4");
    // R3 R5 R6: continuous activity trips the guard
    run(JAB + 20, 1, 0, 0, "R3");
    // R7: partial quiet, activity restarts interval, then full quiet
    run(20, 0, 0, 0, "R7"); run(2, 1, 0, 0, "R7");
    run(UNJAB - 1, 0, 0, 0, "R7"); run(1, 1, 0, 0, "R7");
    run(UNJAB + 5, 0, 0, 0, "R7");
    // R6: status sticky after recovery
    run(6, 0, 0, 0, "R6");
    // R8: clear strobe
    run(1, 0, 0, 1, "R8"); run(4, 0, 0, 0, "R8");
    // R10: fresh count right after release
    run(JAB + 1, 1, 0, 0, "R10"); run(UNJAB + 2, 0, 0, 0, "R10");
    run(1, 0, 0, 1, "R8");
    run(JAB - 1, 1, 0, 0, "R10"); run(3, 0, 0, 0, "R10");
    // R8: clear held across a trip edge, set wins
    run(JAB + 3, 1, 0, 1, "R8"); run(UNJAB + 2, 0, 0, 0, "R8");
    run(2, 0, 0, 1, "R8");
    // R9: collision pass-through and stretch
    run(1, 0, 1, 0, "R9"); run(HOLD + 3, 0, 0, 0, "R9");
    run(4, 0, 1, 0, "R9"); run(HOLD + 3, 0, 0, 0, "R9");
    run(2, 1, 1, 0, "R9"); run(1, 0, 0, 0, "R9");
    run(1, 0, 1, 0, "R9"); run(HOLD + 3, 0, 0, 0, "R9");
    // R5 R9: collision input during jam, released later
    run(JAB + 2, 1, 1, 0, "R5"); run(UNJAB + HOLD + 2, 0, 0, 0, "R5");
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end
endmodule